// File: doc/BRIEF.md
# Device Idle Command Dispatcher

This block is the resting state machine of a serial storage device's command layer. It sits idle until the transport side presents a received frame. For a host command register frame it looks at two flag bits. A soft-reset request is routed to the soft-reset handler. A command flag leads to decoding of the opcode. Any other frame is dropped. A decoded command raises one line of a one-hot dispatch vector toward its command-class handler. An opcode that is not supported raises a one-cycle abort pulse instead.

The block also runs the service path for queued commands. When a queued command is ready to move its data, the dispatcher raises a service pulse and records the queued command's tag and kind. A later SERVICE command then continues the transfer. If the recorded kind is a packet PIO transfer, it goes straight to service decoding. Otherwise it first waits for a status register frame with busy clear, data-request set and the recorded tag. Service decoding then dispatches one of six service handlers.

A dispatch line stays high until the selected handler reports done. The dispatcher then returns to idle.

Top module: `cmd_idle_dispatch`

## Requirements
- R1: After a synchronous reset, `dsp_o`, `abort_o` and `svc_o` are all zero, no service is pending, and the block is idle.
- R2: Only frames with `frm_type` = 0 (command register frame) are inspected in idle. A frame of any other type changes no output, and the block returns to idle.
- R3: A type-0 frame with `frm_srst` = 1 sets `dsp_o` bit 0 (soft-reset handler) on the second rising edge after the frame is sampled. This holds even when `frm_cbit` is also 1: soft reset has priority.
- R4: A type-0 frame with `frm_cbit` = 1, `frm_srst` = 0, and an opcode other than 8'hA2 is supported when opcode[7:4] < 13 and opcode[3] = 0. It sets `dsp_o` bit 1 + opcode[7:4] on the third rising edge after the frame is sampled.
- R5: An unsupported opcode makes `abort_o` high for exactly one cycle, starting on the third rising edge after the frame is sampled. No `dsp_o` bit is set.
- R6: A type-0 frame with both flag bits clear changes no output, and the block returns to idle.
- R7: `dsp_o` is one-hot or zero. Once set, it holds until a cycle with `hdl_done` = 1 and clears on the following edge. Frames that arrive while a dispatch is held are ignored.
- R8: In idle, with no frame present and no service pending, `q_rdy` = 1 latches `q_tag` and `q_kind` and makes `svc_o` high for one cycle. While a service is pending, `q_rdy` has no effect. A frame in the same cycle takes priority, and `q_rdy` is then not taken.
- R9: The SERVICE opcode 8'hA2 with no pending service is treated as unsupported (abort pulse as in R5).
- R10: A SERVICE command with a pending kind of 0 or 1 (packet PIO in/out) sets `dsp_o` bit 14 + kind on the fifth rising edge after the command frame is sampled.
- R11: For a pending kind of 2 or more, the block waits for a `frm_type` = 1 status frame with `frm_bsy` = 0, `frm_drq` = 1 and `frm_tag` equal to the latched tag. Non-matching frames are ignored. A matching frame sets `dsp_o` bit 14 + kind on the second rising edge after it is sampled.
- R12: A pending kind of 6 or 7 has no service handler. It gives a one-cycle abort pulse where R11 would dispatch. In every case, service decoding clears the pending service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | Received frame strobe |
| frm_type | input | 2 | Frame type: 0 command register, 1 status register, others other frames |
| frm_cbit | input | 1 | Command flag of the frame |
| frm_srst | input | 1 | Soft-reset flag of the frame |
| frm_bsy | input | 1 | Busy bit of a status frame |
| frm_drq | input | 1 | Data-request bit of a status frame |
| frm_op | input | 8 | Command opcode |
| frm_tag | input | 5 | Tag carried by the frame |
| q_rdy | input | 1 | Queued command ready for its data transfer (level) |
| q_tag | input | 5 | Tag of the ready queued command |
| q_kind | input | 3 | Service kind of the ready queued command |
| hdl_done | input | 1 | Selected handler has finished |
| dsp_o | output | 20 | One-hot handler dispatch |
| abort_o | output | 1 | Unsupported-command abort pulse |
| svc_o | output | 1 | Service request pulse |

## Verification
The decoder is driven with a vector table that contains:
- supported opcodes at the low end, the middle and the top of the class range;
- opcodes rejected by the high nibble alone or by bit 3 alone;
- the SERVICE opcode with nothing pending.

Together these separate a correct class boundary from an off-by-one range, and a correct bit-3 test from a missing one.

Directed runs then cover the flag filter:
- frames of the wrong type;
- frames with no flags set;
- frames with both flags set, which shows whether the soft-reset priority is wired the right way round.

The service path is tried with a packet kind, which must skip the tag wait. It is also tried with a non-packet kind, preceded by a wrong-tag frame and a busy frame that must not release it, and with an unhandled kind. These runs show whether the tag and status bits are really compared.

// File: rtl/cid_pkg.sv
package cid_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHKFRM, S_CHKCMD, S_SVCTEST, S_SENDTAG, S_SVCDEC, S_DISP
  } cid_state_e;

  localparam logic [1:0] FT_CMD  = 2'd0;
  localparam logic [1:0] FT_STAT = 2'd1;
endpackage

// File: rtl/cid_cmd_decode.sv
module cid_cmd_decode #(
  parameter int OPW = 8,
  parameter int NCLS = 13,
  parameter logic [OPW-1:0] SVC_OP = 8'hA2,
  localparam int CLSW = $clog2(NCLS)
) (
  input  logic [OPW-1:0]  op,
  output logic            is_svc,
  output logic            is_sup,
  output logic [CLSW-1:0] cls
);
  always_comb begin
    cls    = op[OPW-1 -: CLSW];
    is_svc = (op == SVC_OP);
    is_sup = !is_svc && (int'(cls) < NCLS) && !op[OPW-1-CLSW];
  end
endmodule

// File: rtl/cid_onehot.sv
module cid_onehot #(
  parameter int N = 20,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  vec
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign vec[g] = (idx == IW'(g));
  end
endmodule

// File: rtl/cmd_idle_dispatch.sv
module cmd_idle_dispatch
  import cid_pkg::*;
#(
  parameter int OPW = 8,
  parameter int TAGW = 5,
  parameter int KINDW = 3,
  parameter int NCLS = 13,
  parameter int NSVC = 6,
  parameter int NPKT = 2,
  parameter logic [OPW-1:0] SVC_OP = 8'hA2,
  localparam int NDSP = 1 + NCLS + NSVC,
  localparam int DIW = $clog2(NDSP),
  localparam int CLSW = $clog2(NCLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [1:0]       frm_type,
  input  logic             frm_cbit,
  input  logic             frm_srst,
  input  logic             frm_bsy,
  input  logic             frm_drq,
  input  logic [OPW-1:0]   frm_op,
  input  logic [TAGW-1:0]  frm_tag,
  input  logic             q_rdy,
  input  logic [TAGW-1:0]  q_tag,
  input  logic [KINDW-1:0] q_kind,
  input  logic             hdl_done,
  output logic [NDSP-1:0]  dsp_o,
  output logic             abort_o,
  output logic             svc_o
);
  cid_state_e       st;
  logic [1:0]       type_q;
  logic             cbit_q, srst_q;
  logic [OPW-1:0]   op_q;
  logic             pend;
  logic [TAGW-1:0]  ptag;
  logic [KINDW-1:0] pkind;
  logic [NDSP-1:0]  dsp_q;
  logic             abort_q, svc_q;

  logic             is_svc, is_sup;
  logic [CLSW-1:0]  cls;
  logic [DIW-1:0]   idx_c;
  logic [NDSP-1:0]  oh_c;
  logic             tag_hit;

  cid_cmd_decode #(.OPW(OPW), .NCLS(NCLS), .SVC_OP(SVC_OP)) u_dec (
    .op(op_q), .is_svc(is_svc), .is_sup(is_sup), .cls(cls)
  );

  always_comb begin
    case (st)
      S_CHKFRM: idx_c = '0;
      S_CHKCMD: idx_c = DIW'(1) + DIW'(cls);
      default:  idx_c = DIW'(1 + NCLS) + DIW'(pkind);
    endcase
  end

  cid_onehot #(.N(NDSP)) u_oh (.idx(idx_c), .vec(oh_c));

  assign tag_hit = frm_vld && (frm_type == FT_STAT) && !frm_bsy && frm_drq
                   && (frm_tag == ptag);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      type_q  <= '0;
      cbit_q  <= 1'b0;
      srst_q  <= 1'b0;
      op_q    <= '0;
      pend    <= 1'b0;
      ptag    <= '0;
      pkind   <= '0;
      dsp_q   <= '0;
      abort_q <= 1'b0;
      svc_q   <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      svc_q   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (frm_vld) begin
            type_q <= frm_type;
            cbit_q <= frm_cbit;
            srst_q <= frm_srst;
            op_q   <= frm_op;
            st     <= S_CHKFRM;
          end else if (q_rdy && !pend) begin
            pend  <= 1'b1;
            ptag  <= q_tag;
            pkind <= q_kind;
            svc_q <= 1'b1;
          end
        end
        S_CHKFRM: begin
          if (type_q == FT_CMD && srst_q) begin
            dsp_q <= oh_c;
            st    <= S_DISP;
          end else if (type_q == FT_CMD && cbit_q) begin
            st <= S_CHKCMD;
          end else begin
            st <= S_IDLE;
          end
        end
        S_CHKCMD: begin
          if (is_svc && pend) begin
            st <= S_SVCTEST;
          end else if (is_sup) begin
            dsp_q <= oh_c;
            st    <= S_DISP;
          end else begin
            abort_q <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_SVCTEST: st <= (int'(pkind) < NPKT) ? S_SVCDEC : S_SENDTAG;
        S_SENDTAG: if (tag_hit) st <= S_SVCDEC;
        S_SVCDEC: begin
          pend <= 1'b0;
          if (int'(pkind) < NSVC) begin
            dsp_q <= oh_c;
            st    <= S_DISP;
          end else begin
            abort_q <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_DISP: begin
          if (hdl_done) begin
            dsp_q <= '0;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dsp_o   = dsp_q;
  assign abort_o = abort_q;
  assign svc_o   = svc_q;

  // R7
  dsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dsp_q));
  // R7
  dsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|dsp_q && !hdl_done) |=> $stable(dsp_q));
  // R7
  dsp_release_chk: assert property (@(posedge clk) disable iff (rst)
    (|dsp_q && hdl_done) |=> (dsp_q == '0));
  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q);
  // R5
  abort_no_dsp_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> (dsp_q == '0));
  // R8
  svc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    svc_q |=> !svc_q);
  // R8
  svc_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    svc_q |-> pend);
endmodule

// File: tb/sim_cmd_idle_dispatch.sv
module sim_cmd_idle_dispatch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_vld = 1'b0;
  logic [1:0]  frm_type = '0;
  logic        frm_cbit = 1'b0, frm_srst = 1'b0, frm_bsy = 1'b0, frm_drq = 1'b0;
  logic [7:0]  frm_op = '0;
  logic [4:0]  frm_tag = '0;
  logic        q_rdy = 1'b0;
  logic [4:0]  q_tag = '0;
  logic [2:0]  q_kind = '0;
  logic        hdl_done = 1'b0;
  logic [19:0] dsp_o;
  logic        abort_o, svc_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmd_idle_dispatch u0 (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_type(frm_type),
    .frm_cbit(frm_cbit), .frm_srst(frm_srst), .frm_bsy(frm_bsy),
    .frm_drq(frm_drq), .frm_op(frm_op), .frm_tag(frm_tag), .q_rdy(q_rdy),
    .q_tag(q_tag), .q_kind(q_kind), .hdl_done(hdl_done), .dsp_o(dsp_o),
    .abort_o(abort_o), .svc_o(svc_o)
  );

  // op[28:21], expected dispatch[20:1], expected abort[0]
  localparam logic [28:0] VEC [8] = '{
    {8'h00, 20'h00002, 1'b0},
    {8'h30, 20'h00010, 1'b0},
    {8'h57, 20'h00040, 1'b0},
    {8'hC0, 20'h02000, 1'b0},
    {8'hD0, 20'h00000, 1'b1},
    {8'h18, 20'h00000, 1'b1},
    {8'hF3, 20'h00000, 1'b1},
    {8'hA2, 20'h00000, 1'b1}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(logic [1:0] t, logic c, logic s, logic [7:0] op,
                       logic [4:0] tag, logic bsy, logic drq);
    frm_type = t; frm_cbit = c; frm_srst = s; frm_op = op;
    frm_tag = tag; frm_bsy = bsy; frm_drq = drq; frm_vld = 1'b1;
    tick(1);
    frm_vld = 1'b0;
  endtask

  task automatic done_pulse();
    hdl_done = 1'b1;
    tick(1);
    hdl_done = 1'b0;
  endtask

  task automatic qready(logic [4:0] tag, logic [2:0] kind);
    q_rdy = 1'b1; q_tag = tag; q_kind = kind;
    tick(1);
    chk("R8 svc pulse", {31'd0, svc_o}, 32'd1);
    q_rdy = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 dsp", {12'd0, dsp_o}, 32'd0);
    chk("R1 abort/svc", {30'd0, abort_o, svc_o}, 32'd0);

    // R4 R5 R9 opcode table
    for (int i = 0; i < 8; i++) begin
      frame(2'd0, 1'b1, 1'b0, VEC[i][28:21], 5'd0, 1'b0, 1'b0);
      tick(2);
      chk("R4 dispatch", {12'd0, dsp_o}, {12'd0, VEC[i][20:1]});
      chk("R5 abort", {31'd0, abort_o}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        tick(1);
        chk("R5 abort one cycle", {31'd0, abort_o}, 32'd0);
      end else begin
        done_pulse();
        chk("R7 release", {12'd0, dsp_o}, 32'd0);
      end
    end

    // R2 wrong frame types
    frame(2'd2, 1'b1, 1'b0, 8'h00, 5'd0, 1'b0, 1'b0);
    tick(2);
    chk("R2 type2 ignored", {11'd0, abort_o, dsp_o}, 32'd0);
    frame(2'd1, 1'b0, 1'b1, 8'h00, 5'd0, 1'b0, 1'b0);
    tick(2);
    chk("R2 type1 srst ignored", {12'd0, dsp_o}, 32'd0);

    // R6 no flags
    frame(2'd0, 1'b0, 1'b0, 8'h00, 5'd0, 1'b0, 1'b0);
    tick(2);
    chk("R6 no flags", {11'd0, abort_o, dsp_o}, 32'd0);

    // R3 soft reset priority
    frame(2'd0, 1'b1, 1'b1, 8'h00, 5'd0, 1'b0, 1'b0);
    tick(1);
    chk("R3 srst priority", {12'd0, dsp_o}, 32'd1);
    // R7 frames ignored during dispatch
    frame(2'd0, 1'b1, 1'b0, 8'h30, 5'd0, 1'b0, 1'b0);
    tick(2);
    chk("R7 held", {12'd0, dsp_o}, 32'd1);
    done_pulse();
    tick(3);
    chk("R7 ignored frame", {11'd0, abort_o, dsp_o}, 32'd0);

    // R8 frame wins over q_rdy
    q_rdy = 1'b1; q_tag = 5'd1; q_kind = 3'd0;
    frame(2'd0, 1'b0, 1'b0, 8'h00, 5'd0, 1'b0, 1'b0);
    chk("R8 frame priority", {31'd0, svc_o}, 32'd0);
    q_rdy = 1'b0;
    tick(2);

    // R10 packet kind
    qready(5'd5, 3'd0);
    q_rdy = 1'b1;
    tick(1);
    chk("R8 pending blocks svc", {31'd0, svc_o}, 32'd0);
    q_rdy = 1'b0;
    frame(2'd0, 1'b1, 1'b0, 8'hA2, 5'd0, 1'b0, 1'b0);
    tick(3);
    chk("R10 not yet", {12'd0, dsp_o}, 32'd0);
    tick(1);
    chk("R10 packet dispatch", {12'd0, dsp_o}, 32'h4000);
    done_pulse();

    // R11 non-packet kind
    qready(5'd9, 3'd3);
    frame(2'd0, 1'b1, 1'b0, 8'hA2, 5'd0, 1'b0, 1'b0);
    tick(3);
    frame(2'd1, 1'b0, 1'b0, 8'h00, 5'd8, 1'b0, 1'b1);
    tick(1);
    chk("R11 wrong tag", {12'd0, dsp_o}, 32'd0);
    frame(2'd1, 1'b0, 1'b0, 8'h00, 5'd9, 1'b1, 1'b1);
    tick(1);
    chk("R11 busy set", {12'd0, dsp_o}, 32'd0);
    frame(2'd1, 1'b0, 1'b0, 8'h00, 5'd9, 1'b0, 1'b1);
    tick(1);
    chk("R11 match dispatch", {12'd0, dsp_o}, 32'h20000);
    done_pulse();

    // R12 unhandled kind
    qready(5'd2, 3'd6);
    frame(2'd0, 1'b1, 1'b0, 8'hA2, 5'd0, 1'b0, 1'b0);
    tick(3);
    frame(2'd1, 1'b0, 1'b0, 8'h00, 5'd2, 1'b0, 1'b1);
    tick(1);
    chk("R12 abort", {11'd0, abort_o, dsp_o}, 32'h100000);
    // R12 pending cleared: SERVICE now aborts (R9)
    frame(2'd0, 1'b1, 1'b0, 8'hA2, 5'd0, 1'b0, 1'b0);
    tick(2);
    chk("R12 pending cleared", {31'd0, abort_o}, 32'd1);
    tick(1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule